// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block turns CPU-side register accesses into configuration requests for a PCI bus. Software reaches configuration space in one of two ways. The first is indirect: it writes a 32-bit pointer into an address register in I/O space, then reads or writes a data window next to it. The second is a direct memory window. In that window, the position of the lowest set one-hot select bit in the address picks the device, and the low address bits pick the register offset. For each claimed access the block issues one request pulse carrying a config address, a byte size, write data and a write strobe. For reads it waits for the response before it finishes the CPU cycle.

A build option byte-reverses halfword and word data on the direct window for big-endian masters. A separate combinational router folds the interrupt pins of every device onto two host interrupt lines. A pin's route depends on the parity of its pin number plus its device number. Accesses that fall outside every claimed region are left for other targets: the block does not assert its hit flag, issues nothing and never raises ready.

Top module: `pcx_bridge`

## Requirements
- R1: A memory access (cpu_io=0) is claimed (cpu_hit=1) only when its address lies in [0x8080_0000, 0x80C0_0000) and cpu_size is not 3. An I/O access is claimed only at the pointer or data ports. An unclaimed access produces no cfg_req and no cpu_ready.
- R2: In the window, address bits 11 to 21 are scanned upward. The device index is the position (0 to 10) of the lowest set bit, or 11 when none of them is set.
- R3: A window request carries cfg_addr = cpu_addr[10:0] | (index << 11).
- R4: cfg_size repeats cpu_size (0 = byte, 1 = halfword, 2 = word) and cfg_we repeats cpu_we.
- R5: With BIG_ENDIAN=1, window write data is reversed before it is forwarded. A halfword becomes {16'h0, wdata[7:0], wdata[15:8]}, a word has its four bytes reversed, and a byte passes unchanged.
- R6: With BIG_ENDIAN=1, window read data is reversed by the same rule before it reaches cpu_rdata.
- R7: The pointer register sits at I/O address 0xCF8 and answers word accesses only. A write stores the full word and a read returns it. Neither access issues a request. A non-word access there is not claimed and leaves the register unchanged.
- R8: The data port covers I/O addresses 0xCFC to 0xCFF at any size. It issues cfg_addr = {pointer[31:2], cpu_addr[1:0]} and never swaps data.
- R9: cfg_req is a one-cycle pulse in the cycle after the access is accepted. A write ends with a one-cycle cpu_ready in the following cycle. A read ends with cpu_ready in the cycle after cfg_rvalid is seen, and cfg_rvalid counts from the pulse cycle onward. A pointer access raises cpu_ready in the cycle after acceptance.
- R10: For dev_irq bit d*PINS+p, host_irq_a (host line 9) is the OR of the bits where d+p is even. host_irq_b (host line 11) is the OR of the bits where d+p is odd. Levels pass through without a register.
- R11: After reset the pointer register reads zero, and cfg_req and cpu_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access pending; held until cpu_ready |
| cpu_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_we | input | 1 | 1 = write |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | CPU address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_hit | output | 1 | Access is claimed by this block |
| cpu_ready | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cfg_req | output | 1 | Configuration request pulse |
| cfg_we | output | 1 | Request is a write |
| cfg_size | output | 2 | Request byte size code |
| cfg_addr | output | 32 | Bus-relative config address |
| cfg_wdata | output | 32 | Request write data |
| cfg_rvalid | input | 1 | Read response valid |
| cfg_rdata | input | 32 | Read response data |
| dev_irq | input | NUM_DEV*PINS | Device interrupt pins, bit d*PINS+p |
| host_irq_a | output | 1 | Host interrupt line 9 |
| host_irq_b | output | 1 | Host interrupt line 11 |

## Verification
The bench builds the block with BIG_ENDIAN=1, four devices and four pins per device. This brings both reversal paths and the byte bypass within reach, and it lets the data-port accesses show that the swap is limited to the window. Response latencies of zero to three cycles cover a response that lands in the pulse cycle as well as one that arrives during the wait. The four-by-four interrupt grid reaches both parities of device plus pin.

// File: rtl/pcx_pkg.sv
`timescale 1ns/1ps
package pcx_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ISSUE = 2'd1,
      PH_WAIT  = 2'd2,
      PH_DONE  = 2'd3
   } phase_e;

endpackage

// File: rtl/pcx_win_decode.sv
`timescale 1ns/1ps
module pcx_win_decode #(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8080_0000,
   parameter logic [ADDR_W-1:0] WIN_SPAN = 32'h0040_0000,
   parameter int                SEL_LO   = 11,
   parameter int                SEL_CNT  = 11
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] cfg_addr
);

   localparam int IDX_W = $clog2(SEL_CNT + 1);
   localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + {1'b0, WIN_SPAN};

   generate
      if (SEL_LO < 1 || SEL_CNT < 1 || SEL_LO + SEL_CNT > ADDR_W) begin : g_bad_sel
         $error("pcx_win_decode: select field does not fit the address");
      end
      if (WIN_SPAN == '0 || (WIN_SPAN & (WIN_SPAN - 1'b1)) != '0) begin : g_bad_span
         $error("pcx_win_decode: window span must be a power of two");
      end
      if ((WIN_BASE & (WIN_SPAN - 1'b1)) != '0) begin : g_bad_base
         $error("pcx_win_decode: window base must be aligned to its span");
      end
   endgenerate

   assign hit = ({1'b0, addr} >= {1'b0, WIN_BASE}) && ({1'b0, addr} < WIN_END);

   logic [SEL_CNT-1:0] sel;
   logic [SEL_CNT:0]   seen;
   logic [SEL_CNT-1:0] first;
   logic [IDX_W-1:0]   idx;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < SEL_CNT; i++) begin : g_scan
         assign sel[i]      = addr[SEL_LO + i];
         assign first[i]    = sel[i] & ~seen[i];
         assign seen[i + 1] = seen[i] | sel[i];
      end
   endgenerate

   always_comb begin
      idx = seen[SEL_CNT] ? '0 : IDX_W'(SEL_CNT);
      for (int i = 0; i < SEL_CNT; i++) begin
         idx = idx | (first[i] ? IDX_W'(i) : '0);
      end
   end

   assign cfg_addr = ADDR_W'(addr[SEL_LO-1:0]) | (ADDR_W'(idx) << SEL_LO);

   // R2: at most one select position wins, and the winner is a set bit
   always_comb begin
      assert_first_onehot_R2 : assert ($onehot0(first));
      if (idx != IDX_W'(SEL_CNT)) begin
         assert_idx_set_R2 : assert (addr[SEL_LO + int'(idx)]);
      end
   end

endmodule

// File: rtl/pcx_bswap.sv
`timescale 1ns/1ps
module pcx_bswap
   import pcx_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("pcx_bswap: word size code assumes 32-bit data");
      end
   endgenerate

   logic [DATA_W-1:0] rev_word;
   logic [DATA_W-1:0] rev_half;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign rev_word[8*i +: 8] = din[8*(LANES-1-i) +: 8];
      end
   endgenerate

   assign rev_half = DATA_W'({din[7:0], din[15:8]});

   generate
      if (BIG_ENDIAN) begin : g_be
         always_comb begin
            case (xfer_size_e'(size))
               SZ_HALF: dout = rev_half;
               SZ_WORD: dout = rev_word;
               default: dout = din;
            endcase
         end
      end else begin : g_le
         assign dout = din;
      end
   endgenerate

   // R5/R6: single bytes are never reordered
   always_comb begin
      if (xfer_size_e'(size) == SZ_BYTE) begin
         assert_byte_intact_R5 : assert (dout == din);
      end
   end

endmodule

// File: rtl/pcx_irq_route.sv
`timescale 1ns/1ps
module pcx_irq_route #(
   parameter int NUM_DEV = 4,
   parameter int PINS    = 4
) (
   input  logic [NUM_DEV*PINS-1:0] dev_irq,
   output logic                    line_a,
   output logic                    line_b
);

   localparam int NSRC = NUM_DEV * PINS;

   generate
      if (NUM_DEV < 1 || NUM_DEV > 32 || PINS < 1 || PINS > 4) begin : g_bad_cfg
         $error("pcx_irq_route: device or pin count out of range");
      end
   endgenerate

   logic [NSRC-1:0] to_a;
   logic [NSRC-1:0] to_b;

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_src
         localparam int DEV = g / PINS;
         localparam int PIN = g % PINS;
         if (((DEV + PIN) % 2) == 0) begin : g_even
            assign to_a[g] = dev_irq[g];
            assign to_b[g] = 1'b0;
         end else begin : g_odd
            assign to_a[g] = 1'b0;
            assign to_b[g] = dev_irq[g];
         end
      end
   endgenerate

   assign line_a = |to_a;
   assign line_b = |to_b;

   // R10: quiet pins leave both host lines low
   always_comb begin
      if (dev_irq == '0) begin
         assert_quiet_lines_R10 : assert (!line_a && !line_b);
      end
   end

endmodule

// File: rtl/pcx_bridge.sv
`timescale 1ns/1ps
module pcx_bridge
   import pcx_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_W     = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8080_0000,
   parameter logic [ADDR_W-1:0] WIN_SPAN   = 32'h0040_0000,
   parameter int                SEL_LO     = 11,
   parameter int                SEL_CNT    = 11,
   parameter logic [ADDR_W-1:0] PTR_PORT   = 32'h0000_0CF8,
   parameter logic [ADDR_W-1:0] DATA_PORT  = 32'h0000_0CFC,
   parameter bit                BIG_ENDIAN = 1'b0,
   parameter int                NUM_DEV    = 4,
   parameter int                PINS       = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_io,
   input  logic                    cpu_we,
   input  logic [1:0]              cpu_size,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   output logic                    cpu_hit,
   output logic                    cpu_ready,
   output logic [DATA_W-1:0]       cpu_rdata,
   output logic                    cfg_req,
   output logic                    cfg_we,
   output logic [1:0]              cfg_size,
   output logic [ADDR_W-1:0]       cfg_addr,
   output logic [DATA_W-1:0]       cfg_wdata,
   input  logic                    cfg_rvalid,
   input  logic [DATA_W-1:0]       cfg_rdata,
   input  logic [NUM_DEV*PINS-1:0] dev_irq,
   output logic                    host_irq_a,
   output logic                    host_irq_b
);

   generate
      if (ADDR_W != DATA_W) begin : g_bad_widths
         $error("pcx_bridge: pointer register needs address and data of equal width");
      end
      if (PTR_PORT[1:0] != 2'b00 || DATA_PORT[1:0] != 2'b00) begin : g_bad_ports
         $error("pcx_bridge: I/O ports must be word aligned");
      end
   endgenerate

   // ---------------- decode ----------------
   logic              dec_hit;
   logic [ADDR_W-1:0] win_cfg_addr;
   logic              size_ok;
   logic              win_hit;
   logic              ptr_hit;
   logic              dat_hit;

   pcx_win_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_BASE (WIN_BASE),
      .WIN_SPAN (WIN_SPAN),
      .SEL_LO   (SEL_LO),
      .SEL_CNT  (SEL_CNT)
   ) u_dec (
      .addr     (cpu_addr),
      .hit      (dec_hit),
      .cfg_addr (win_cfg_addr)
   );

   assign size_ok = (xfer_size_e'(cpu_size) != SZ_RSVD);
   assign win_hit = !cpu_io && dec_hit && size_ok;
   assign ptr_hit = cpu_io && (cpu_addr[ADDR_W-1:2] == PTR_PORT[ADDR_W-1:2])
                    && (xfer_size_e'(cpu_size) == SZ_WORD);
   assign dat_hit = cpu_io && (cpu_addr[ADDR_W-1:2] == DATA_PORT[ADDR_W-1:2]) && size_ok;
   assign cpu_hit = win_hit || ptr_hit || dat_hit;

   // ---------------- data reordering ----------------
   logic [DATA_W-1:0] wr_swapped;
   logic [DATA_W-1:0] rd_swapped;

   pcx_bswap #(
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_wr_swap (
      .size (cpu_size),
      .din  (cpu_wdata),
      .dout (wr_swapped)
   );

   pcx_bswap #(
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_rd_swap (
      .size (cfg_size),
      .din  (cfg_rdata),
      .dout (rd_swapped)
   );

   // ---------------- sequencing ----------------
   phase_e            ph;
   logic [DATA_W-1:0] ptr_q;
   logic [DATA_W-1:0] rdat_q;
   logic              c_we;
   logic [1:0]        c_size;
   logic [ADDR_W-1:0] c_addr;
   logic [DATA_W-1:0] c_wdat;
   logic              c_swap;
   logic [DATA_W-1:0] rd_ret;

   assign rd_ret = c_swap ? rd_swapped : cfg_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         ptr_q  <= '0;
         rdat_q <= '0;
         c_we   <= 1'b0;
         c_size <= 2'b00;
         c_addr <= '0;
         c_wdat <= '0;
         c_swap <= 1'b0;
      end else begin
         case (ph)
            PH_IDLE: begin
               if (cpu_req && cpu_hit) begin
                  if (ptr_hit) begin
                     if (cpu_we) ptr_q  <= cpu_wdata;
                     else        rdat_q <= ptr_q;
                     ph <= PH_DONE;
                  end else begin
                     c_we   <= cpu_we;
                     c_size <= cpu_size;
                     c_addr <= win_hit ? win_cfg_addr : {ptr_q[ADDR_W-1:2], cpu_addr[1:0]};
                     c_wdat <= win_hit ? wr_swapped : cpu_wdata;
                     c_swap <= win_hit;
                     ph     <= PH_ISSUE;
                  end
               end
            end
            PH_ISSUE: begin
               if (c_we) begin
                  ph <= PH_DONE;
               end else if (cfg_rvalid) begin
                  rdat_q <= rd_ret;
                  ph     <= PH_DONE;
               end else begin
                  ph <= PH_WAIT;
               end
            end
            PH_WAIT: begin
               if (cfg_rvalid) begin
                  rdat_q <= rd_ret;
                  ph     <= PH_DONE;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign cfg_req   = (ph == PH_ISSUE);
   assign cfg_we    = c_we;
   assign cfg_size  = c_size;
   assign cfg_addr  = c_addr;
   assign cfg_wdata = c_wdat;
   assign cpu_ready = (ph == PH_DONE);
   assign cpu_rdata = rdat_q;

   // ---------------- interrupts ----------------
   pcx_irq_route #(
      .NUM_DEV (NUM_DEV),
      .PINS    (PINS)
   ) u_irq (
      .dev_irq (dev_irq),
      .line_a  (host_irq_a),
      .line_b  (host_irq_b)
   );

   // ---------------- assertions ----------------
   assert_req_pulse_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |=> !cfg_req);

   assert_ready_pulse_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   assert_write_finish_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_we) |=> cpu_ready);

   assert_read_finish_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WAIT && cfg_rvalid) |=> cpu_ready);

   assert_unclaimed_quiet_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE && cpu_req && !cpu_hit) |=> (!cfg_req && !cpu_ready));

   assert_ptr_store_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE && cpu_req && ptr_hit && cpu_we) |=> (ptr_q == $past(cpu_wdata)));

   assert_ptr_no_request_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE && cpu_req && ptr_hit) |=> (!cfg_req && cpu_ready));

endmodule

// File: tb/tb_pcx_bridge.sv
`timescale 1ns/1ps
module tb_pcx_bridge;

   localparam int ND = 4;
   localparam int NP = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cpu_req = 1'b0;
   logic             cpu_io = 1'b0;
   logic             cpu_we = 1'b0;
   logic [1:0]       cpu_size = 2'd0;
   logic [31:0]      cpu_addr = '0;
   logic [31:0]      cpu_wdata = '0;
   logic             cpu_hit;
   logic             cpu_ready;
   logic [31:0]      cpu_rdata;
   logic             cfg_req;
   logic             cfg_we;
   logic [1:0]       cfg_size;
   logic [31:0]      cfg_addr;
   logic [31:0]      cfg_wdata;
   logic             cfg_rvalid = 1'b0;
   logic [31:0]      cfg_rdata = '0;
   logic [ND*NP-1:0] dev_irq = '0;
   logic             host_irq_a;
   logic             host_irq_b;

   always #2 clk = ~clk;

   pcx_bridge #(
      .BIG_ENDIAN (1'b1),
      .NUM_DEV    (ND),
      .PINS       (NP)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .cpu_req (cpu_req), .cpu_io (cpu_io), .cpu_we (cpu_we),
      .cpu_size (cpu_size), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
      .cpu_hit (cpu_hit), .cpu_ready (cpu_ready), .cpu_rdata (cpu_rdata),
      .cfg_req (cfg_req), .cfg_we (cfg_we), .cfg_size (cfg_size),
      .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
      .cfg_rvalid (cfg_rvalid), .cfg_rdata (cfg_rdata),
      .dev_irq (dev_irq), .host_irq_a (host_irq_a), .host_irq_b (host_irq_b)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------- behavioural reference pieces ----------
   function automatic logic [31:0] resp_of(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
   endfunction

   function automatic logic [31:0] sw16(input logic [31:0] x);
      return {16'h0, x[7:0], x[15:8]};
   endfunction

   function automatic logic [31:0] sw32(input logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   function automatic logic [1:0] irq_ref(input logic [ND*NP-1:0] v);
      logic [1:0] r = 2'b00;
      for (int d = 0; d < ND; d++) begin
         for (int p = 0; p < NP; p++) begin
            if (v[d*NP+p]) r[(d+p)%2] = 1'b1;
         end
      end
      return r;
   endfunction

   // ---------- request recorder ----------
   int          nreq = 0;
   logic [31:0] rec_addr = '0;
   logic [31:0] rec_wdata = '0;
   logic [1:0]  rec_size = '0;
   logic        rec_we = 1'b0;

   initial begin
      forever begin
         @(negedge clk);
         if (cfg_req === 1'b1) begin
            nreq++;
            rec_addr  = cfg_addr;
            rec_wdata = cfg_wdata;
            rec_size  = cfg_size;
            rec_we    = cfg_we;
         end
      end
   end

   // ---------- config responder ----------
   int          lat = 0;
   int          cnt = 0;
   bit          pend = 1'b0;
   logic [31:0] paddr = '0;

   initial begin
      forever begin
         @(negedge clk);
         cfg_rvalid = 1'b0;
         if (cfg_req === 1'b1 && cfg_we === 1'b0) begin
            pend  = 1'b1;
            cnt   = lat;
            paddr = cfg_addr;
         end
         if (pend) begin
            if (cnt == 0) begin
               cfg_rvalid = 1'b1;
               cfg_rdata  = resp_of(paddr);
               pend       = 1'b0;
            end else begin
               cnt--;
            end
         end
      end
   end

   // ---------- per-clock interrupt comparison (R10) ----------
   always @(posedge clk) begin
      if (rst_n) begin
         chk("R10", "irq lines", {30'h0, host_irq_b, host_irq_a}, {30'h0, irq_ref(dev_irq)});
      end
   end

   // ---------- access driver ----------
   task automatic access(input string req, input bit io, input bit we,
                         input logic [1:0] size, input logic [31:0] addr,
                         input logic [31:0] wdata, input bit claim,
                         input int exp_wait, output logic [31:0] rdata);
      int base;
      int waited;
      @(negedge clk);
      cpu_io = io; cpu_we = we; cpu_size = size; cpu_addr = addr;
      cpu_wdata = wdata; cpu_req = 1'b1;
      base = nreq;
      #1;
      chk(req, "cpu_hit", {31'h0, cpu_hit}, {31'h0, claim});
      rdata = '0;
      if (!claim) begin
         repeat (6) begin
            @(negedge clk);
            chk(req, "no ready on unclaimed", {31'h0, cpu_ready}, 32'h0);
         end
         chk(req, "no request on unclaimed", nreq - base, 0);
         cpu_req = 1'b0;
      end else begin
         waited = 0;
         do begin
            @(negedge clk);
            waited++;
         end while (cpu_ready !== 1'b1 && waited < 40);
         rdata   = cpu_rdata;
         cpu_req = 1'b0;
         chk(req, "completion cycle", waited, exp_wait);
      end
   endtask

   task automatic check_req(input string req, input int exp_n, input int base,
                            input logic [31:0] a, input logic [1:0] s,
                            input bit w, input logic [31:0] wd);
      chk(req, "request count", nreq - base, exp_n);
      chk(req, "cfg_addr", rec_addr, a);
      chk(req, "cfg_size", {30'h0, rec_size}, {30'h0, s});
      chk(req, "cfg_we", {31'h0, rec_we}, {31'h0, w});
      if (w) chk(req, "cfg_wdata", rec_wdata, wd);
   endtask

   task automatic set_irq(input logic [ND*NP-1:0] v);
      @(negedge clk);
      dev_irq = v;
      #1;
      chk("R10", "irq pattern", {30'h0, host_irq_b, host_irq_a}, {30'h0, irq_ref(v)});
   endtask

   // ---------- watchdog ----------
   initial begin
      #(4 * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   // ---------- main sequence ----------
   initial begin
      logic [31:0] rd;
      int b;

      repeat (4) @(negedge clk);
      chk("R11", "cfg_req in reset", {31'h0, cfg_req}, 32'h0);
      chk("R11", "cpu_ready in reset", {31'h0, cpu_ready}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "cfg_req after reset", {31'h0, cfg_req}, 32'h0);

      // R11 / R7: pointer reads zero after reset
      b = nreq;
      access("R11", 1, 0, 2'd2, 32'hCF8, 0, 1, 1, rd);
      chk("R11", "pointer reset value", rd, 32'h0);
      chk("R7", "pointer read issues nothing", nreq - b, 0);

      // R2 R3 R4 R5: word write, select bit 13 -> device 2
      b = nreq;
      access("R5", 0, 1, 2'd2, 32'h8080_2010, 32'h1122_3344, 1, 2, rd);
      check_req("R3", 1, b, 32'h0000_1010, 2'd2, 1, 32'h4433_2211);

      // R2 R6: halfword read, bits 15 and 19 set -> device 4, zero latency
      lat = 0;
      b = nreq;
      access("R6", 0, 0, 2'd1, 32'h8088_87FC, 0, 1, 2, rd);
      check_req("R2", 1, b, 32'h0000_27FC, 2'd1, 0, 0);
      chk("R6", "halfword read swap", rd, sw16(resp_of(32'h0000_27FC)));

      // R2 R5: no select bit -> device 11, byte write unswapped
      b = nreq;
      access("R5", 0, 1, 2'd0, 32'h8080_0044, 32'h0000_00A5, 1, 2, rd);
      check_req("R2", 1, b, 32'h0000_5844, 2'd0, 1, 32'h0000_00A5);

      // R2 R6 R9: bit 21 only -> device 10, word read, latency 3
      lat = 3;
      b = nreq;
      access("R9", 0, 0, 2'd2, 32'h80A0_0008, 0, 1, 5, rd);
      check_req("R2", 1, b, 32'h0000_5008, 2'd2, 0, 0);
      chk("R6", "word read swap", rd, sw32(resp_of(32'h0000_5008)));

      // R1 R6: last byte of window, byte read unswapped, latency 1
      lat = 1;
      b = nreq;
      access("R1", 0, 0, 2'd0, 32'h80BF_FFFF, 0, 1, 3, rd);
      check_req("R3", 1, b, 32'h0000_07FF, 2'd0, 0, 0);
      chk("R6", "byte read unswapped", rd, resp_of(32'h0000_07FF));

      // R1: outside the window or in the wrong space
      access("R1", 0, 1, 2'd2, 32'h80C0_0000, 32'hDEAD_BEEF, 0, 0, rd);
      access("R1", 0, 0, 2'd2, 32'h807F_FFFC, 0, 0, 0, rd);
      access("R1", 1, 1, 2'd2, 32'h8080_2010, 32'h1, 0, 0, rd);
      access("R1", 0, 1, 2'd3, 32'h8080_2010, 32'h1, 0, 0, rd);

      // R7: pointer write and read back
      b = nreq;
      access("R7", 1, 1, 2'd2, 32'hCF8, 32'h8000_0A10, 1, 1, rd);
      access("R7", 1, 0, 2'd2, 32'hCF8, 0, 1, 1, rd);
      chk("R7", "pointer read back", rd, 32'h8000_0A10);
      chk("R7", "pointer accesses issue nothing", nreq - b, 0);

      // R7: a byte write to the pointer is not claimed and changes nothing
      access("R7", 1, 1, 2'd0, 32'hCF8, 32'h0000_00FF, 0, 0, rd);
      access("R7", 1, 0, 2'd2, 32'hCF8, 0, 1, 1, rd);
      chk("R7", "pointer kept after byte write", rd, 32'h8000_0A10);

      // R8: data port halfword write, offset 2, no swap
      b = nreq;
      access("R8", 1, 1, 2'd1, 32'hCFE, 32'h0000_BEEF, 1, 2, rd);
      check_req("R8", 1, b, 32'h8000_0A12, 2'd1, 1, 32'h0000_BEEF);

      // R8 R9: data port word read, latency 2, no swap
      lat = 2;
      b = nreq;
      access("R8", 1, 0, 2'd2, 32'hCFC, 0, 1, 4, rd);
      check_req("R8", 1, b, 32'h8000_0A10, 2'd2, 0, 0);
      chk("R8", "data port read unswapped", rd, resp_of(32'h8000_0A10));

      // R10: interrupt routing patterns
      set_irq(16'h0001);
      set_irq(16'h0010);
      set_irq(16'h0200);
      set_irq(16'h8000);
      set_irq(16'h0021);
      set_irq(16'hFFFF);
      set_irq(16'h0000);
      repeat (3) @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule